// File: doc/BRIEF.md
# Trace Enable Gate

This block decides, cycle by cycle, whether a processor trace unit may emit trace. It forms a single registered `trace_en` output from three conditions that must all hold together: a programmable enabling event picked from a vector of event resources, a start/stop latch that is set and cleared by masked address comparator and watchpoint matches, and an address range test whose polarity can be flipped between "trace only inside" and "trace only outside" the selected range comparators.

The start/stop latch can be taken out of the final decision by a control bit. Its state is still driven on `ss_state` in every configuration, so other trace logic can use it as a resource. All control fields are loaded through a small synchronous write port. The final output and the latch both appear one clock after the match inputs that cause them.

Top module: `trace_gate`

## Requirements
- R1: After reset, `trace_en` and `ss_state` are 0 and every control field is 0.
- R2: A write with `cfg_we`=1 updates one register at the next rising edge and affects outputs from the cycle after. Address 0: bit 0 latch gate enable, bit 1 exclude mode, bits 5:2 range comparator select. Address 1: bits 7:0 comparator start mask, bits 15:8 comparator stop mask. Address 2: bits 3:0 watchpoint start mask, bits 7:4 watchpoint stop mask. Address 3: bits 3:0 index of the enabling event in `evt_res`.
- R3: `trace_en` is 1 only if `evt_res[index]` was 1 in the previous cycle.
- R4: A comparator or watchpoint match whose start mask bit is set turns `ss_state` on at the next edge.
- R5: A match whose stop mask bit is set turns `ss_state` off at the next edge, and a stop wins over a start in the same cycle.
- R6: Matches whose mask bits are clear leave `ss_state` unchanged.
- R7: With the gate enable bit at 1, `trace_en` also needs the updated latch state to be 1; with it at 0 the latch does not affect `trace_en`, while `ss_state` keeps following start and stop.
- R8: In include mode (exclude bit 0) with a non-empty range select, `trace_en` needs at least one selected range comparator to match.
- R9: In exclude mode, `trace_en` needs no selected range comparator to match; with an empty select the range condition holds.
- R10: In include mode with an empty range select, the range condition holds.
- R11: `trace_en` in each cycle equals the AND of the conditions formed from the inputs of the previous cycle and the latch state updated by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| sac_hit | input | 8 | Single address comparator matches |
| arc_hit | input | 4 | Address range comparator matches |
| wpt_hit | input | 4 | Watchpoint matches |
| evt_res | input | 16 | Event resource values |
| trace_en | output | 1 | Final trace enable |
| ss_state | output | 1 | Start/stop latch state |

## Verification
The bench drives start and stop together to catch a latch that lets start win, which would leave tracing on after a stop. It turns the gate enable bit off while the latch toggles to catch a design that either gates `trace_en` on the latch anyway or freezes `ss_state`. It runs include mode with an empty range select, where a literal OR-of-matches test would block all trace, and exclude mode with matching ranges, where a wrong polarity would let excluded code through. A random phase with register writes mixed into live traffic catches off-by-one errors in when a new setting or a new latch state reaches `trace_en`.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;
    parameter int N_SAC  = 8;
    parameter int N_ARC  = 4;
    parameter int N_WPT  = 4;
    parameter int N_EVT  = 16;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 2;
    localparam int EVT_SEL_W = $clog2(N_EVT);

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_SAC  = 2'd1;
    localparam logic [ADDR_W-1:0] REG_WPT  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_EVT  = 2'd3;

    typedef struct packed {
        logic                 ss_gate_en;
        logic                 excl_mode;
        logic [N_ARC-1:0]     arc_sel;
        logic [N_SAC-1:0]     sac_start;
        logic [N_SAC-1:0]     sac_stop;
        logic [N_WPT-1:0]     wpt_start;
        logic [N_WPT-1:0]     wpt_stop;
        logic [EVT_SEL_W-1:0] evt_sel;
    } cfg_t;
endpackage

// File: rtl/tg_cfg_regs.sv
module tg_cfg_regs
    import trace_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                REG_CTRL: begin
                    cfg_d.ss_gate_en = wr_data[0];
                    cfg_d.excl_mode  = wr_data[1];
                    cfg_d.arc_sel    = wr_data[2 +: N_ARC];
                end
                REG_SAC: begin
                    cfg_d.sac_start = wr_data[0 +: N_SAC];
                    cfg_d.sac_stop  = wr_data[N_SAC +: N_SAC];
                end
                REG_WPT: begin
                    cfg_d.wpt_start = wr_data[0 +: N_WPT];
                    cfg_d.wpt_stop  = wr_data[N_WPT +: N_WPT];
                end
                default: cfg_d.evt_sel = wr_data[0 +: EVT_SEL_W];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/tg_ss_latch.sv
module tg_ss_latch
    import trace_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SAC-1:0] sac_hit,
    input  logic [N_WPT-1:0] wpt_hit,
    input  logic [N_SAC-1:0] sac_start_msk,
    input  logic [N_SAC-1:0] sac_stop_msk,
    input  logic [N_WPT-1:0] wpt_start_msk,
    input  logic [N_WPT-1:0] wpt_stop_msk,
    output logic             state_d_o,
    output logic             state_q_o
);
    logic go, halt;
    logic state_d, state_q;

    always_comb begin
        go   = |(sac_hit & sac_start_msk) | |(wpt_hit & wpt_start_msk);
        halt = |(sac_hit & sac_stop_msk)  | |(wpt_hit & wpt_stop_msk);
        state_d = state_q;
        if (halt)    state_d = 1'b0;
        else if (go) state_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= state_d;
    end

    assign state_d_o = state_d;
    assign state_q_o = state_q;
endmodule

// File: rtl/tg_range_gate.sv
module tg_range_gate
    import trace_gate_pkg::*;
(
    input  logic [N_ARC-1:0] arc_hit,
    input  logic [N_ARC-1:0] arc_sel,
    input  logic             excl_mode,
    output logic             ok_o
);
    logic any_sel, any_hit;

    always_comb begin
        any_sel = |arc_sel;
        any_hit = |(arc_hit & arc_sel);
        if (excl_mode)     ok_o = ~any_hit;
        else if (!any_sel) ok_o = 1'b1;
        else               ok_o = any_hit;
    end
endmodule

// File: rtl/trace_gate.sv
module trace_gate
    import trace_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_SAC-1:0]  sac_hit,
    input  logic [N_ARC-1:0]  arc_hit,
    input  logic [N_WPT-1:0]  wpt_hit,
    input  logic [N_EVT-1:0]  evt_res,
    output logic              trace_en,
    output logic              ss_state
);
    typedef struct packed {
        logic te;
    } out_t;

    cfg_t cfg_q;
    logic ss_next, ss_q, range_ok;
    out_t out_d, out_q;

    tg_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .cfg_o   (cfg_q)
    );

    tg_ss_latch u_ss (
        .clk           (clk),
        .rst_n         (rst_n),
        .sac_hit       (sac_hit),
        .wpt_hit       (wpt_hit),
        .sac_start_msk (cfg_q.sac_start),
        .sac_stop_msk  (cfg_q.sac_stop),
        .wpt_start_msk (cfg_q.wpt_start),
        .wpt_stop_msk  (cfg_q.wpt_stop),
        .state_d_o     (ss_next),
        .state_q_o     (ss_q)
    );

    tg_range_gate u_rg (
        .arc_hit   (arc_hit),
        .arc_sel   (cfg_q.arc_sel),
        .excl_mode (cfg_q.excl_mode),
        .ok_o      (range_ok)
    );

    always_comb begin
        out_d.te = evt_res[cfg_q.evt_sel]
                 & (ss_next | ~cfg_q.ss_gate_en)
                 & range_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign trace_en = out_q.te;
    assign ss_state = ss_q;
endmodule

// File: rtl/trace_gate_chk.sv
module trace_gate_chk
    import trace_gate_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input cfg_t             cfg,
    input logic [N_SAC-1:0] sac_hit,
    input logic [N_ARC-1:0] arc_hit,
    input logic [N_WPT-1:0] wpt_hit,
    input logic [N_EVT-1:0] evt_res,
    input logic             trace_en,
    input logic             ss_state
);
    logic start_any, stop_any;
    assign start_any = (|(sac_hit & cfg.sac_start)) || (|(wpt_hit & cfg.wpt_start));
    assign stop_any  = (|(sac_hit & cfg.sac_stop))  || (|(wpt_hit & cfg.wpt_stop));

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!trace_en && !ss_state)); // R1

    AST_EVENT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_res[cfg.evt_sel] |=> !trace_en); // R3

    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_any && !stop_any) |=> ss_state); // R4

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_any |=> !ss_state); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_any && !stop_any) |=> $stable(ss_state)); // R6

    AST_GATED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.ss_gate_en && stop_any) |=> !trace_en); // R7

    AST_INCLUDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.excl_mode && (|cfg.arc_sel) && !(|(arc_hit & cfg.arc_sel))) |=> !trace_en); // R8

    AST_EXCLUDE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.excl_mode && (|(arc_hit & cfg.arc_sel))) |=> !trace_en); // R9
endmodule

bind trace_gate trace_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_q),
    .sac_hit  (sac_hit),
    .arc_hit  (arc_hit),
    .wpt_hit  (wpt_hit),
    .evt_res  (evt_res),
    .trace_en (trace_en),
    .ss_state (ss_state)
);

// File: tb/trace_gate_tb_top.sv
module trace_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  sac_hit = '0;
    logic [3:0]  arc_hit = '0;
    logic [3:0]  wpt_hit = '0;
    logic [15:0] evt_res = '0;
    logic        trace_en, ss_state;

    always #4 clk = ~clk;

    trace_gate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sac_hit(sac_hit), .arc_hit(arc_hit),
        .wpt_hit(wpt_hit), .evt_res(evt_res), .trace_en(trace_en),
        .ss_state(ss_state)
    );

    // reference model state
    bit       m_gate, m_excl, m_ss, m_te;
    bit [3:0] m_arc, m_wst, m_wsp, m_evt;
    bit [7:0] m_sst, m_ssp;
    int       n_vec = 0;
    int       n_bad = 0;
    bit       done = 1'b0;
    string    tag = "R1";

    always @(posedge clk) begin
        bit st, sp, ok;
        if (!rst_n) begin
            {m_gate, m_excl, m_ss, m_te} = '0;
            {m_arc, m_wst, m_wsp, m_evt, m_sst, m_ssp} = '0;
        end else begin
            st = ((sac_hit & m_sst) != 0) || ((wpt_hit & m_wst) != 0);
            sp = ((sac_hit & m_ssp) != 0) || ((wpt_hit & m_wsp) != 0);
            if (sp) m_ss = 1'b0;
            else if (st) m_ss = 1'b1;
            if (m_excl) ok = ((arc_hit & m_arc) == 0);
            else if (m_arc == 0) ok = 1'b1;
            else ok = ((arc_hit & m_arc) != 0);
            m_te = evt_res[m_evt] && (m_ss || !m_gate) && ok;
            if (cfg_we) begin
                case (cfg_addr)
                    2'd0: begin m_gate = cfg_wdata[0]; m_excl = cfg_wdata[1]; m_arc = cfg_wdata[5:2]; end
                    2'd1: begin m_sst = cfg_wdata[7:0]; m_ssp = cfg_wdata[15:8]; end
                    2'd2: begin m_wst = cfg_wdata[3:0]; m_wsp = cfg_wdata[7:4]; end
                    default: m_evt = cfg_wdata[3:0];
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (trace_en !== m_te || ss_state !== m_ss) begin
                n_bad++;
                $display("FAIL %s: trace_en=%b ss_state=%b expected trace_en=%b ss_state=%b",
                         tag, trace_en, ss_state, m_te, m_ss);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hits(input logic [7:0] s, input logic [3:0] a,
                        input logic [3:0] w, input logic [15:0] e);
        @(negedge clk);
        sac_hit = s; arc_hit = a; wpt_hit = w; evt_res = e;
    endtask

    initial begin
        // R1: reset state
        step(3);
        n_vec++;
        if (trace_en !== 1'b0 || ss_state !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: trace_en=%b ss_state=%b expected 0 0", trace_en, ss_state);
        end
        rst_n = 1'b1;
        // R10 / R3: defaults (event 0, include, empty select)
        tag = "R10";
        hits(8'h00, 4'h0, 4'h0, 16'h0001); step(2);
        hits(8'h00, 4'hF, 4'h0, 16'h0000); step(2);
        // R2/R3: select event 5
        tag = "R3";
        wr(2'd3, 16'h0005);
        hits(8'h00, 4'h0, 4'h0, 16'h0001); step(2);
        hits(8'h00, 4'h0, 4'h0, 16'h0020); step(2);
        // R4/R5/R7: latch with gate on
        tag = "R2";
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h0201);
        wr(2'd2, 16'h0084);
        tag = "R4";
        hits(8'h01, 4'h0, 4'h0, 16'h0020);
        hits(8'h00, 4'h0, 4'h0, 16'h0020); step(2);
        tag = "R5";
        hits(8'h02, 4'h0, 4'h0, 16'h0020);
        hits(8'h00, 4'h0, 4'h4, 16'h0020);
        hits(8'h00, 4'h0, 4'hC, 16'h0020);
        hits(8'h01, 4'h0, 4'h8, 16'h0020);
        hits(8'h00, 4'h0, 4'h0, 16'h0020); step(2);
        tag = "R6";
        hits(8'hFC, 4'h0, 4'h3, 16'h0020); step(2);
        hits(8'h01, 4'h0, 4'h0, 16'h0020);
        hits(8'hFC, 4'h0, 4'h3, 16'h0020); step(2);
        tag = "R7";
        wr(2'd0, 16'h0000);
        hits(8'h02, 4'h0, 4'h0, 16'h0020); step(2);
        hits(8'h01, 4'h0, 4'h0, 16'h0020); step(2);
        hits(8'h02, 4'h0, 4'h0, 16'h0020); step(2);
        // R8: include with ranges 0 and 2
        tag = "R8";
        wr(2'd0, 16'h0014);
        hits(8'h00, 4'h1, 4'h0, 16'h0020);
        hits(8'h00, 4'h2, 4'h0, 16'h0020);
        hits(8'h00, 4'h4, 4'h0, 16'h0020);
        hits(8'h00, 4'h0, 4'h0, 16'h0020); step(2);
        // R9: exclude
        tag = "R9";
        wr(2'd0, 16'h0016);
        hits(8'h00, 4'h1, 4'h0, 16'h0020);
        hits(8'h00, 4'h2, 4'h0, 16'h0020);
        hits(8'h00, 4'h0, 4'h0, 16'h0020);
        wr(2'd0, 16'h0002);
        hits(8'h00, 4'hF, 4'h0, 16'h0020); step(2);
        // R11: random traffic with live writes
        tag = "R11";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            sac_hit = 8'($urandom) & 8'($urandom);
            arc_hit = 4'($urandom);
            wpt_hit = 4'($urandom) & 4'($urandom);
            evt_res = 16'($urandom) | 16'($urandom);
            cfg_we  = ($urandom % 8) == 0;
            cfg_addr  = 2'($urandom);
            cfg_wdata = 16'($urandom) & 16'($urandom);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL R11: watchdog expired, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule